// File: doc/BRIEF.md
# Bank-Switched Memory Address Mapper

This block sits between an 8-bit CPU with a 64 KiB address space and its memories. On each bus access it decides where that access goes. The possible targets are main RAM, a 12 KiB upper ROM, one of two 4 KiB peripheral ROM images, or a peripheral strobe. An access can also be dropped, or a read can be forced to return zero. The memories and the peripherals are outside the block. The block only produces addresses, selects and enables, one clock after the access is presented.

A four-bit mode register sets the behaviour of the top 12 KiB of the address space. Any read or write in the sixteen-byte soft-switch window at $C080-$C08F loads the low address nibble into this register. The mode controls three things:

- whether upper reads are served from ROM or from RAM;
- whether upper RAM can be written;
- which of two 4 KiB RAM banks appears at $D000-$DFFF. The alternate bank is placed in the physical RAM hole at $C000-$CFFF.

Reads and writes to the same upper address can therefore reach different targets. Three external flags mark missing memory. When a flag is set, the affected reads return zero and the affected writes are discarded.

Top module: `bank_switch_mapper`

## Requirements
- R1: A valid access to $C000-$C0FF asserts `io_stb` with `io_we` equal to `bus_we` and `io_addr` equal to the low address byte. It asserts no RAM enable, gives `rom_sel` 2'b00 and leaves `rd_zero` low.
- R2: With all absent flags clear, a read or write to $0000-$BFFF asserts `ram_re` or `ram_we` with `ram_addr` equal to the CPU address.
- R3: A read or write to $C080-$C08F loads address bits [3:0] into the mode. The new mode governs the following accesses. The loading access is itself routed as in R1.
- R4: Upper writes ($D000-$FFFF) are discarded, with no enable asserted, when mode bit 0 is 0. When mode bit 0 is 1 they assert `ram_we`.
- R5: Upper reads go to ROM when mode bit 1 XOR mode bit 0 is 1, and to RAM otherwise. This choice does not affect where upper writes go.
- R6: When mode bit 3 is 0, RAM accesses to $D000-$DFFF use the same physical address. When it is 1, they use the address minus $1000 ($C000-$CFFF).
- R7: RAM accesses to $E000-$FFFF use the same physical address for every mode.
- R8: An upper ROM read gives `rom_sel` 2'b01 and `rom_addr` equal to the CPU address minus $D000.
- R9: A read of $C100-$CFFF gives `rom_sel` 2'b10 when `slot_rom_sel` is 0, or 2'b11 when it is 1, with `rom_addr` equal to address bits [11:0]. A write there asserts no output.
- R10: After reset the mode is 4'b0001: $D000 bank at the same physical address, upper RAM writable, upper reads from ROM. All outputs are low while reset is held.
- R11: With `no_page2` set, reads of $0400-$07FF assert only `rd_zero`, and writes there assert nothing.
- R12: With `no_aux_rd` set, every non-peripheral read at $0200 or above asserts only `rd_zero`. Reads below $0200 still reach RAM.
- R13: With `no_aux_wr` set, every write outside $C000-$C0FF asserts nothing.
- R14: Every output is registered and shows the routing of the access sampled at the previous clock edge. A cycle with `bus_valid` low leaves all enables, `rom_sel` and `rd_zero` at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | CPU access present this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | CPU address |
| slot_rom_sel | input | 1 | Picks the second peripheral ROM image |
| no_page2 | input | 1 | Display page 2 memory absent |
| no_aux_rd | input | 1 | Auxiliary read memory absent |
| no_aux_wr | input | 1 | Auxiliary write memory absent |
| ram_addr | output | 16 | Physical RAM address |
| ram_re | output | 1 | RAM read enable |
| ram_we | output | 1 | RAM write enable |
| rom_sel | output | 2 | ROM target: 00 none, 01 upper, 10 image A, 11 image B |
| rom_addr | output | 14 | ROM offset |
| io_stb | output | 1 | Peripheral strobe |
| io_we | output | 1 | Peripheral access is a write |
| io_addr | output | 8 | Peripheral register offset |
| rd_zero | output | 1 | Read data must be forced to 0x00 |

## Verification
The bench tries all sixteen mode values against all sixteen settings of the four side inputs. For each pair it issues a read and a write at region edges such as $01FF/$0200, $03FF/$0400, $BFFF/$C000, $CFFF/$D000 and $DFFF/$E000. The reads show whether the XOR rule picks ROM or RAM. The writes expose write protection that is independent of the read source. The $D000-$DFFF results separate the two bank placements from the fixed $E000 window. Alternating read and write strobes for the mode loads shows that both kinds of access update the mode, and that the change takes effect on the next access and not on the loading one.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;

  typedef enum logic [1:0] {
    ROM_NONE  = 2'b00,
    ROM_UPPER = 2'b01,
    ROM_IO_A  = 2'b10,
    ROM_IO_B  = 2'b11
  } rom_sel_e;

  typedef struct packed {
    logic bank_alt;   // $D000 window relocated to $C000
    logic upr_wr_en;  // upper RAM writable
    logic upr_rd_rom; // upper reads from ROM
  } map_mode_t;

endpackage

// File: rtl/bank_mode_reg.sv
module bank_mode_reg #(
  parameter int ADDR_W = 16,
  parameter logic [15:0] SW_BASE = 16'hC080,
  parameter logic [3:0]  RST_MODE = 4'b0001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [3:0]        mode_q,
  output bank_map_pkg::map_mode_t mode_dec
);
  localparam int HI_W = ADDR_W - 4;
  localparam logic [HI_W-1:0] SW_HI = SW_BASE[ADDR_W-1:4];

  logic hit;
  assign hit = bus_valid && (bus_addr[ADDR_W-1:4] == SW_HI);

  always_ff @(posedge clk) begin
    if (rst) mode_q <= RST_MODE;
    else if (hit) mode_q <= bus_addr[3:0];
  end

  always_comb begin
    mode_dec.bank_alt   = mode_q[3];
    mode_dec.upr_wr_en  = mode_q[0];
    mode_dec.upr_rd_rom = mode_q[1] ^ mode_q[0];
  end
endmodule

// File: rtl/bank_access_decode.sv
module bank_access_decode #(
  parameter int ADDR_W   = 16,
  parameter int ROM_AW   = 14,
  parameter int IOROM_AW = 12,
  parameter int BANK_SZ  = 4096
) (
  input  logic                    bus_valid,
  input  logic                    bus_we,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic                    slot_rom_sel,
  input  logic                    no_page2,
  input  logic                    no_aux_rd,
  input  logic                    no_aux_wr,
  input  bank_map_pkg::map_mode_t mode_dec,
  output logic [ADDR_W-1:0]       n_ram_addr,
  output logic                    n_ram_re,
  output logic                    n_ram_we,
  output logic [1:0]              n_rom_sel,
  output logic [ROM_AW-1:0]       n_rom_addr,
  output logic                    n_io_stb,
  output logic                    n_io_we,
  output logic [7:0]              n_io_addr,
  output logic                    n_rd_zero
);
  import bank_map_pkg::*;

  localparam logic [ADDR_W-1:0] IO_BASE    = ADDR_W'(16'hC000);
  localparam logic [ADDR_W-1:0] IO_END     = ADDR_W'(16'hC100);
  localparam logic [ADDR_W-1:0] UPR_BASE   = ADDR_W'(16'hD000);
  localparam logic [ADDR_W-1:0] FIX_BASE   = IO_BASE + ADDR_W'(3 * BANK_SZ - BANK_SZ);
  localparam logic [ADDR_W-1:0] AUX_BASE   = ADDR_W'(16'h0200);
  localparam logic [ADDR_W-1:0] PG2_BASE   = ADDR_W'(16'h0400);
  localparam logic [ADDR_W-1:0] PG2_END    = ADDR_W'(16'h0800);
  localparam logic [ADDR_W-1:0] BANK_SHIFT = ADDR_W'(BANK_SZ);

  logic in_io, in_low, in_slot, in_upr, in_bank_win, in_pg2, above_aux;
  logic [ADDR_W-1:0] phys_upr;
  logic [ADDR_W-1:0] upr_off;

  always_comb begin
    in_io       = (bus_addr >= IO_BASE) && (bus_addr < IO_END);
    in_low      = bus_addr < IO_BASE;
    in_slot     = (bus_addr >= IO_END) && (bus_addr < UPR_BASE);
    in_upr      = bus_addr >= UPR_BASE;
    in_bank_win = in_upr && (bus_addr < FIX_BASE);
    in_pg2      = (bus_addr >= PG2_BASE) && (bus_addr < PG2_END);
    above_aux   = bus_addr >= AUX_BASE;
    phys_upr    = (in_bank_win && mode_dec.bank_alt) ? bus_addr - BANK_SHIFT : bus_addr;
    upr_off     = bus_addr - UPR_BASE;
  end

  always_comb begin
    n_ram_addr = '0;
    n_ram_re   = 1'b0;
    n_ram_we   = 1'b0;
    n_rom_sel  = ROM_NONE;
    n_rom_addr = '0;
    n_io_stb   = 1'b0;
    n_io_we    = 1'b0;
    n_io_addr  = '0;
    n_rd_zero  = 1'b0;
    if (bus_valid) begin
      if (in_io) begin
        n_io_stb  = 1'b1;
        n_io_we   = bus_we;
        n_io_addr = bus_addr[7:0];
      end else if (!bus_we) begin
        if (no_page2 && in_pg2) begin
          n_rd_zero = 1'b1;
        end else if (no_aux_rd && above_aux) begin
          n_rd_zero = 1'b1;
        end else if (in_low) begin
          n_ram_re   = 1'b1;
          n_ram_addr = bus_addr;
        end else if (in_slot) begin
          n_rom_sel  = slot_rom_sel ? ROM_IO_B : ROM_IO_A;
          n_rom_addr = ROM_AW'(bus_addr[IOROM_AW-1:0]);
        end else if (mode_dec.upr_rd_rom) begin
          n_rom_sel  = ROM_UPPER;
          n_rom_addr = upr_off[ROM_AW-1:0];
        end else begin
          n_ram_re   = 1'b1;
          n_ram_addr = phys_upr;
        end
      end else begin
        if (no_page2 && in_pg2) begin
          n_ram_we = 1'b0;
        end else if (no_aux_wr) begin
          n_ram_we = 1'b0;
        end else if (in_low) begin
          n_ram_we   = 1'b1;
          n_ram_addr = bus_addr;
        end else if (in_upr && mode_dec.upr_wr_en) begin
          n_ram_we   = 1'b1;
          n_ram_addr = phys_upr;
        end
      end
    end
  end
endmodule

// File: rtl/bank_route_regs.sv
module bank_route_regs #(
  parameter int ADDR_W = 16,
  parameter int ROM_AW = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] n_ram_addr,
  input  logic              n_ram_re,
  input  logic              n_ram_we,
  input  logic [1:0]        n_rom_sel,
  input  logic [ROM_AW-1:0] n_rom_addr,
  input  logic              n_io_stb,
  input  logic              n_io_we,
  input  logic [7:0]        n_io_addr,
  input  logic              n_rd_zero,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_re,
  output logic              ram_we,
  output logic [1:0]        rom_sel,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              io_stb,
  output logic              io_we,
  output logic [7:0]        io_addr,
  output logic              rd_zero
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ram_addr <= '0;
      ram_re   <= 1'b0;
      ram_we   <= 1'b0;
      rom_sel  <= '0;
      rom_addr <= '0;
      io_stb   <= 1'b0;
      io_we    <= 1'b0;
      io_addr  <= '0;
      rd_zero  <= 1'b0;
    end else begin
      ram_addr <= n_ram_addr;
      ram_re   <= n_ram_re;
      ram_we   <= n_ram_we;
      rom_sel  <= n_rom_sel;
      rom_addr <= n_rom_addr;
      io_stb   <= n_io_stb;
      io_we    <= n_io_we;
      io_addr  <= n_io_addr;
      rd_zero  <= n_rd_zero;
    end
  end
endmodule

// File: rtl/bank_switch_mapper.sv
module bank_switch_mapper #(
  parameter int ADDR_W   = 16,
  parameter int ROM_AW   = 14,
  parameter int IOROM_AW = 12,
  parameter int BANK_SZ  = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              slot_rom_sel,
  input  logic              no_page2,
  input  logic              no_aux_rd,
  input  logic              no_aux_wr,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_re,
  output logic              ram_we,
  output logic [1:0]        rom_sel,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              io_stb,
  output logic              io_we,
  output logic [7:0]        io_addr,
  output logic              rd_zero
);
  logic [3:0] mode_q;
  bank_map_pkg::map_mode_t mode_dec;

  logic [ADDR_W-1:0] n_ram_addr;
  logic              n_ram_re, n_ram_we, n_io_stb, n_io_we, n_rd_zero;
  logic [1:0]        n_rom_sel;
  logic [ROM_AW-1:0] n_rom_addr;
  logic [7:0]        n_io_addr;

  bank_mode_reg #(.ADDR_W(ADDR_W)) u_mode (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .mode_q(mode_q), .mode_dec(mode_dec)
  );

  bank_access_decode #(
    .ADDR_W(ADDR_W), .ROM_AW(ROM_AW), .IOROM_AW(IOROM_AW), .BANK_SZ(BANK_SZ)
  ) u_dec (
    .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
    .slot_rom_sel(slot_rom_sel), .no_page2(no_page2),
    .no_aux_rd(no_aux_rd), .no_aux_wr(no_aux_wr), .mode_dec(mode_dec),
    .n_ram_addr(n_ram_addr), .n_ram_re(n_ram_re), .n_ram_we(n_ram_we),
    .n_rom_sel(n_rom_sel), .n_rom_addr(n_rom_addr), .n_io_stb(n_io_stb),
    .n_io_we(n_io_we), .n_io_addr(n_io_addr), .n_rd_zero(n_rd_zero)
  );

  bank_route_regs #(.ADDR_W(ADDR_W), .ROM_AW(ROM_AW)) u_regs (
    .clk(clk), .rst(rst),
    .n_ram_addr(n_ram_addr), .n_ram_re(n_ram_re), .n_ram_we(n_ram_we),
    .n_rom_sel(n_rom_sel), .n_rom_addr(n_rom_addr), .n_io_stb(n_io_stb),
    .n_io_we(n_io_we), .n_io_addr(n_io_addr), .n_rd_zero(n_rd_zero),
    .ram_addr(ram_addr), .ram_re(ram_re), .ram_we(ram_we),
    .rom_sel(rom_sel), .rom_addr(rom_addr), .io_stb(io_stb),
    .io_we(io_we), .io_addr(io_addr), .rd_zero(rd_zero)
  );
endmodule

// File: rtl/bank_switch_mapper_chk.sv
module bank_switch_mapper_chk #(
  parameter int ADDR_W = 16,
  parameter int ROM_AW = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [3:0]        mode_q,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              ram_re,
  input logic              ram_we,
  input logic [1:0]        rom_sel,
  input logic [ROM_AW-1:0] rom_addr,
  input logic              io_stb,
  input logic              rd_zero
);
  // R1
  io_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    io_stb |-> (!ram_re && !ram_we && rom_sel == 2'b00 && !rd_zero));

  // R14
  one_target_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ram_re, ram_we, rom_sel != 2'b00, io_stb, rd_zero}));

  // R14
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |=> (!ram_re && !ram_we && !io_stb && !rd_zero && rom_sel == 2'b00));

  // R3
  mode_load_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_addr[ADDR_W-1:4] == 12'hC08) |=> (mode_q == $past(bus_addr[3:0])));

  // R4
  upper_protect_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_we && bus_addr >= 16'hD000 && !mode_q[0]) |=> !ram_we);

  // R8
  upper_rom_range_chk: assert property (@(posedge clk) disable iff (rst)
    (rom_sel == 2'b01) |-> (rom_addr < 14'h3000));

  // R9
  rom_never_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_we) |=> (rom_sel == 2'b00 && !ram_re));
endmodule

bind bank_switch_mapper bank_switch_mapper_chk #(.ADDR_W(ADDR_W), .ROM_AW(ROM_AW)) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
  .mode_q(mode_q), .ram_addr(ram_addr), .ram_re(ram_re), .ram_we(ram_we),
  .rom_sel(rom_sel), .rom_addr(rom_addr), .io_stb(io_stb), .rd_zero(rd_zero)
);

// File: tb/tb_bank_switch_mapper.sv
module tb_bank_switch_mapper;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0, bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        slot_rom_sel = 1'b0, no_page2 = 1'b0, no_aux_rd = 1'b0, no_aux_wr = 1'b0;
  logic [15:0] ram_addr;
  logic        ram_re, ram_we, io_stb, io_we, rd_zero;
  logic [1:0]  rom_sel;
  logic [13:0] rom_addr;
  logic [7:0]  io_addr;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [3:0] cur_mode;

  always #4 clk = ~clk;

  bank_switch_mapper dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
    .slot_rom_sel(slot_rom_sel), .no_page2(no_page2), .no_aux_rd(no_aux_rd),
    .no_aux_wr(no_aux_wr), .ram_addr(ram_addr), .ram_re(ram_re), .ram_we(ram_we),
    .rom_sel(rom_sel), .rom_addr(rom_addr), .io_stb(io_stb), .io_we(io_we),
    .io_addr(io_addr), .rd_zero(rd_zero)
  );

  // expected outputs packed: {re, we, sel[1:0], stb, iowe, zero}
  logic [6:0]  e_flags;
  logic [15:0] e_ram;
  logic [13:0] e_rom;
  logic [7:0]  e_io;
  string       e_tag;

  task automatic expect_route(input logic [15:0] a, input logic w, input logic [3:0] m);
    logic [15:0] phys;
    e_flags = '0; e_ram = '0; e_rom = '0; e_io = '0;
    phys = (m[3] && a >= 16'hD000 && a < 16'hE000) ? a - 16'h1000 : a;
    if (a >= 16'hC000 && a < 16'hC100) begin
      e_flags = {4'b0000, 1'b1, w, 1'b0}; e_io = a[7:0]; e_tag = "R1";
    end else if (!w) begin
      if (no_page2 && a >= 16'h0400 && a < 16'h0800) begin
        e_flags[0] = 1'b1; e_tag = "R11";
      end else if (no_aux_rd && a >= 16'h0200) begin
        e_flags[0] = 1'b1; e_tag = "R12";
      end else if (a < 16'hC000) begin
        e_flags[6] = 1'b1; e_ram = a; e_tag = "R2";
      end else if (a < 16'hD000) begin
        e_flags[4:3] = slot_rom_sel ? 2'b11 : 2'b10; e_rom = {2'b00, a[11:0]}; e_tag = "R9";
      end else if (m[1] ^ m[0]) begin
        e_flags[4:3] = 2'b01; e_rom = 14'(a - 16'hD000); e_tag = "R5/R8";
      end else begin
        e_flags[6] = 1'b1; e_ram = phys; e_tag = (a < 16'hE000) ? "R5/R6" : "R5/R7";
      end
    end else begin
      if (no_page2 && a >= 16'h0400 && a < 16'h0800) e_tag = "R11";
      else if (no_aux_wr) e_tag = "R13";
      else if (a < 16'hC000) begin e_flags[5] = 1'b1; e_ram = a; e_tag = "R2"; end
      else if (a < 16'hD000) e_tag = "R9";
      else if (m[0]) begin
        e_flags[5] = 1'b1; e_ram = phys; e_tag = (a < 16'hE000) ? "R4/R6" : "R4/R7";
      end else e_tag = "R4";
    end
  endtask

  task automatic compare(input string tag, input logic [15:0] a);
    logic [6:0] got;
    bit bad;
    got = {ram_re, ram_we, rom_sel, io_stb, io_we, rd_zero};
    bad = (got[6:2] != e_flags[6:2]) || (got[0] != e_flags[0]);
    if (e_flags[2] && (io_we != e_flags[1] || io_addr != e_io)) bad = 1'b1;
    if ((e_flags[6] || e_flags[5]) && ram_addr != e_ram) bad = 1'b1;
    if (e_flags[4:3] != 2'b00 && rom_addr != e_rom) bad = 1'b1;
    checks++;
    if (bad) begin
      failures++;
      $display("FAIL %s addr=%h we=%0b mode=%h got flags=%b ram=%h rom=%h io=%h exp flags=%b ram=%h rom=%h io=%h",
               tag, a, bus_we, cur_mode, got, ram_addr, rom_addr, io_addr, e_flags, e_ram, e_rom, e_io);
    end
  endtask

  // called at a negedge: drive, wait one edge, sample at next negedge
  task automatic access(input logic [15:0] a, input logic w, input string tag_over);
    expect_route(a, w, cur_mode);
    bus_valid = 1'b1; bus_we = w; bus_addr = a;
    @(negedge clk);
    compare((tag_over != "") ? tag_over : e_tag, a);
    if (a[15:4] == 12'hC08) cur_mode = a[3:0];
  endtask

  localparam int NS = 15;
  logic [15:0] samples [NS] = '{16'h0000, 16'h01FF, 16'h0200, 16'h03FF, 16'h0400,
                                16'h07FF, 16'h0800, 16'hBFFF, 16'hC000, 16'hC0A5,
                                16'hC100, 16'hCFFF, 16'hD000, 16'hDFFF, 16'hE000};

  initial begin
    cur_mode = 4'b0001;
    repeat (3) @(negedge clk);
    // R10: outputs low during reset
    e_flags = '0; e_ram = '0; e_rom = '0; e_io = '0;
    compare("R10", 16'h0000);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset mode - ROM reads, writable, bank at same address
    access(16'hD123, 1'b0, "R10");
    access(16'hD123, 1'b1, "R10");
    access(16'hC234, 1'b0, "R10");
    access(16'hFFFF, 1'b0, "R10");
    access(16'hFFFF, 1'b1, "R10");
    // R14: idle cycle clears everything
    bus_valid = 1'b0;
    e_flags = '0;
    @(negedge clk);
    compare("R14", 16'h0000);
    for (int f = 0; f < 16; f++) begin
      slot_rom_sel = f[0]; no_page2 = f[1]; no_aux_rd = f[2]; no_aux_wr = f[3];
      for (int m = 0; m < 16; m++) begin
        // R3: mode load by read (even) or write (odd); routed as I/O
        access(16'hC080 | 16'(m), m[0], "R3");
        // R3: new mode applies immediately to the next access
        access(16'hD010, 1'b0, "");
        for (int s = 0; s < NS; s++) begin
          access(samples[s], 1'b0, "");
          access(samples[s], 1'b1, "");
        end
        access(16'hFFFF, 1'b0, "");
        access(16'hFFFF, 1'b1, "");
      end
    end
    bus_valid = 1'b0;
    e_flags = '0;
    @(negedge clk);
    compare("R14", 16'h0000);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R14 watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule